// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned N-bit operands in a single combinational path and returns the full 2N-bit product. An AND array first builds one shifted copy of the multiplicand for each multiplier bit. A tree of 3-to-2 carry-save rows then reduces these summands. Every row takes three vectors and returns a sum vector and a carry vector at the same time, with no carry moving along the row. The vectors are regrouped in threes at each level until only two are left. One ripple-carry adder then joins those two into the product. Carry propagates along the full word only in this last adder.

The block has no clock and no state. A new product is ready one settling delay after either operand changes. It suits a datapath that places its own registers around it. The operand width N is a parameter. The number of tree levels, and the count of vectors at each level, are worked out from N at elaboration.

Top module: `carry_save_mul`

## Requirements
- R1: A multiplier with only bit j set gives a product equal to the multiplicand shifted left by j places, zero-extended to 2N bits. This confirms that summand j is the multiplicand ANDed with multiplier bit j and placed j positions up.
- R2: For every pair of N-bit unsigned operands, the 2N-bit product equals their arithmetic product. With N=6, 45 times 63 gives 2835.
- R3: If either operand is zero, the product is zero.
- R4: With both operands at 2^N-1, the product is 2^(2N)-2^(N+1)+1. This value needs carries that run through the whole final adder. The two vectors left by the tree add, modulo 2^(2N), to the product.
- R5: Product bit 0 equals multiplicand bit 0 AND multiplier bit 0. The carry vector out of the tree always has bit 0 clear, because each carry sits one position above its sum.
- R6: The product depends only on the present operands. It settles within one clock period after the operands change, and no earlier operand value affects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | N | Unsigned multiplicand |
| mplier | input | N | Unsigned multiplier; bit j selects summand j |
| product | output | 2N | Unsigned product of mcand and mplier |

## Verification
The bench builds two copies of the block. One uses N=6, where six summands pass through three carry-save levels (6, 4, 3, 2 vectors), and one of those levels carries a leftover vector past its group. The other uses N=3, where a single row reduces three summands directly to two. Each copy is run over every operand pair its width allows, so both the leftover path and the no-leftover path are covered, along with the all-ones case that carries along the whole word. Directed cases cover one-hot multipliers, zero operands and the low product bit.

// File: rtl/csm_pkg.sv
package csm_pkg;

  // Vectors present at tree level lvl when starting from n summands.
  function automatic int vec_count(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) begin
      c = 2 * (c / 3) + (c % 3);
    end
    return c;
  endfunction

  // Levels of 3-to-2 reduction needed to reach at most two vectors.
  function automatic int level_count(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = 2 * (c / 3) + (c % 3);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/csm_pp_gen.sv
module csm_pp_gen #(
  parameter int N = 6,
  localparam int W = 2 * N
) (
  input  logic [N-1:0]        mcand,
  input  logic [N-1:0]        mplier,
  output logic [N-1:0][W-1:0] summand
);

  for (genvar j = 0; j < N; j++) begin : g_row
    logic [N-1:0] gated;
    assign gated = mcand & {N{mplier[j]}};
    if (j == 0) begin : g_low
      assign summand[j] = {{(W-N){1'b0}}, gated};
    end else if (j == N - 1 && N + j == W - 1) begin : g_top
      assign summand[j] = {1'b0, gated, {j{1'b0}}};
    end else begin : g_mid
      assign summand[j] = {{(W-N-j){1'b0}}, gated, {j{1'b0}}};
    end
  end

endmodule

// File: rtl/csm_csa_row.sv
module csm_csa_row #(
  parameter int W = 12
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);

  assign cry_o[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = in_a[i] ^ in_b[i] ^ in_c[i];
    if (i < W - 1) begin : g_cy
      assign cry_o[i+1] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
    end
  end

endmodule

// File: rtl/csm_tree.sv
module csm_tree
  import csm_pkg::*;
#(
  parameter int N = 6,
  localparam int W      = 2 * N,
  localparam int LEVELS = level_count(N),
  localparam int LAST   = vec_count(N, LEVELS)
) (
  input  logic [N-1:0][W-1:0] summand,
  output logic [W-1:0]        sum_vec,
  output logic [W-1:0]        carry_vec
);

  logic [N-1:0][W-1:0] stage [0:LEVELS];

  assign stage[0] = summand;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CIN  = vec_count(N, l);
    localparam int GRP  = CIN / 3;
    localparam int REM  = CIN % 3;
    localparam int COUT = 2 * GRP + REM;

    for (genvar g = 0; g < GRP; g++) begin : g_grp
      csm_csa_row #(.W(W)) u_row (
        .in_a  (stage[l][3*g]),
        .in_b  (stage[l][3*g+1]),
        .in_c  (stage[l][3*g+2]),
        .sum_o (stage[l+1][2*g]),
        .cry_o (stage[l+1][2*g+1])
      );
    end

    for (genvar r = 0; r < REM; r++) begin : g_pass
      assign stage[l+1][2*GRP+r] = stage[l][3*GRP+r];
    end

    for (genvar u = COUT; u < N; u++) begin : g_idle
      assign stage[l+1][u] = '0;
    end
  end

  assign sum_vec = stage[LEVELS][0];

  if (LAST >= 2) begin : g_two
    assign carry_vec = stage[LEVELS][1];
  end else begin : g_one
    assign carry_vec = '0;
  end

endmodule

// File: rtl/csm_cpa.sv
module csm_cpa #(
  parameter int W = 12
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] total
);

  logic [W-1:0] cin;

  assign cin[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign total[i] = op_a[i] ^ op_b[i] ^ cin[i];
    if (i < W - 1) begin : g_c
      assign cin[i+1] = (op_a[i] & op_b[i]) | (cin[i] & (op_a[i] ^ op_b[i]));
    end
  end

endmodule

// File: rtl/carry_save_mul.sv
module carry_save_mul #(
  parameter int N = 6
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product
);

  localparam int W = 2 * N;

  logic [N-1:0][W-1:0] summand;
  logic [W-1:0]        sum_vec;
  logic [W-1:0]        carry_vec;

  csm_pp_gen #(.N(N)) u_pp (
    .mcand   (mcand),
    .mplier  (mplier),
    .summand (summand)
  );

  csm_tree #(.N(N)) u_tree (
    .summand   (summand),
    .sum_vec   (sum_vec),
    .carry_vec (carry_vec)
  );

  csm_cpa #(.W(W)) u_cpa (
    .op_a  (sum_vec),
    .op_b  (carry_vec),
    .total (product)
  );

endmodule

// File: rtl/carry_save_mul_chk.sv
module carry_save_mul_chk #(
  parameter int N = 6
) (
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] product,
  input logic [2*N-1:0] sum_vec,
  input logic [2*N-1:0] carry_vec
);

  localparam int W = 2 * N;

  logic [W-1:0] ext_a;
  logic [W-1:0] ext_b;
  logic [W-1:0] ref_p;
  logic [W-1:0] joined;

  assign ext_a  = {{N{1'b0}}, mcand};
  assign ext_b  = {{N{1'b0}}, mplier};
  assign ref_p  = ext_a * ext_b;
  assign joined = sum_vec + carry_vec;

  always_comb begin
    if (!$isunknown({mcand, mplier, product, sum_vec, carry_vec})) begin
      assert_product_value_R2: assert (product == ref_p)
        else $error("R2 product mismatch");
      assert_zero_operand_R3: assert (!(mcand == '0 || mplier == '0) || product == '0)
        else $error("R3 zero operand gave nonzero product");
      assert_vectors_join_R4: assert (joined == product)
        else $error("R4 tree vectors do not add to product");
      assert_carry_low_clear_R5: assert (carry_vec[0] == 1'b0)
        else $error("R5 carry vector bit 0 set");
      assert_low_bit_R5: assert (product[0] == (mcand[0] & mplier[0]))
        else $error("R5 product bit 0 wrong");
    end
  end

endmodule

bind carry_save_mul carry_save_mul_chk #(.N(N)) u_chk (
  .mcand     (mcand),
  .mplier    (mplier),
  .product   (product),
  .sum_vec   (sum_vec),
  .carry_vec (carry_vec)
);

// File: tb/test_carry_save_mul.sv
module test_carry_save_mul;

  localparam int NA = 6;
  localparam int NB = 3;

  logic clk;
  logic rst_n;
  logic [NA-1:0]   a6, b6;
  logic [2*NA-1:0] p6;
  logic [NB-1:0]   a3, b3;
  logic [2*NB-1:0] p3;

  int checks;
  int errors;
  int cycles;
  bit done;

  carry_save_mul #(.N(NA)) i_carry_save_mul (
    .mcand (a6), .mplier (b6), .product (p6)
  );

  carry_save_mul #(.N(NB)) i_carry_save_mul_n3 (
    .mcand (a3), .mplier (b3), .product (p3)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input longint x6, input longint y6, input longint x3, input longint y3);
    @(posedge clk);
    a6 = NA'(x6); b6 = NA'(y6);
    a3 = NB'(x3); b3 = NB'(y3);
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    a6 = '0; b6 = '0; a3 = '0; b3 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset zero operands n6", longint'(p6), 0);
    chk("R3 reset zero operands n3", longint'(p3), 0);
  endtask

  task automatic t_one_hot;
    for (int j = 0; j < NA; j++) begin
      drive(45, longint'(1) << j, 5, longint'(1) << (j % NB));
      chk("R1 one-hot multiplier n6", longint'(p6), longint'(45) << j);
      chk("R1 one-hot multiplier n3", longint'(p3), longint'(5) << (j % NB));
    end
  endtask

  task automatic t_example;
    drive(45, 63, 6, 7);
    chk("R2 45x63 n6", longint'(p6), 2835);
    chk("R2 6x7 n3", longint'(p3), 42);
  endtask

  task automatic t_zero;
    drive(0, 63, 7, 0);
    chk("R3 zero multiplicand n6", longint'(p6), 0);
    chk("R3 zero multiplier n3", longint'(p3), 0);
    drive(51, 0, 0, 5);
    chk("R3 zero multiplier n6", longint'(p6), 0);
    chk("R3 zero multiplicand n3", longint'(p3), 0);
  endtask

  task automatic t_all_ones;
    drive(63, 63, 7, 7);
    chk("R4 all ones n6", longint'(p6), (longint'(1) << 12) - (longint'(1) << 7) + 1);
    chk("R4 all ones n3", longint'(p3), (longint'(1) << 6) - (longint'(1) << 4) + 1);
  endtask

  task automatic t_low_bit;
    drive(33, 21, 3, 5);
    chk("R5 low bit odd*odd n6", longint'(p6[0]), 1);
    chk("R5 low bit odd*odd n3", longint'(p3[0]), 1);
    drive(33, 20, 2, 5);
    chk("R5 low bit odd*even n6", longint'(p6[0]), 0);
    chk("R5 low bit even*odd n3", longint'(p3[0]), 0);
  endtask

  task automatic t_history;
    drive(63, 63, 7, 7);
    drive(2, 3, 1, 1);
    chk("R6 no memory of prior operands n6", longint'(p6), 6);
    chk("R6 no memory of prior operands n3", longint'(p3), 1);
  endtask

  task automatic t_exhaustive;
    int bad;
    bad = 0;
    for (int x = 0; x < (1 << NA); x++) begin
      for (int y = 0; y < (1 << NA); y++) begin
        drive(x, y, x % (1 << NB), y % (1 << NB));
        if (longint'(p6) != longint'(x) * longint'(y)) begin
          if (bad < 8)
            $display("FAIL R2 exhaustive n6 %0d*%0d: actual=%0d expected=%0d", x, y, p6, x * y);
          bad++;
        end
        if (longint'(p3) != longint'(x % (1 << NB)) * longint'(y % (1 << NB))) begin
          if (bad < 8)
            $display("FAIL R2 exhaustive n3 %0d*%0d: actual=%0d expected=%0d",
                     x % (1 << NB), y % (1 << NB), p3, (x % (1 << NB)) * (y % (1 << NB)));
          bad++;
        end
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    cycles = 0;
    done   = 1'b0;
    t_reset_state();
    t_one_hot();
    t_example();
    t_zero();
    t_all_ones();
    t_low_bit();
    t_history();
    t_exhaustive();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule